// File: doc/BRIEF.md
# Hotplug Event Status Registers

This block is a small byte-addressed register file that tells host software about processor and slot hotplug events. A sideband source announces that a processor (by index) or an expansion slot (by index) has been inserted or removed. The block updates its bitmaps, records the event class in an event status register, and raises a one-cycle interrupt pulse when software has enabled that class.

Software reaches six 16-bit registers through an 8-bit bus, one byte per address:
- a live processor-present bitmap, which the bus can only read;
- a firmware copy of that bitmap, which the bus can write;
- an event status register with write-1-to-clear bits;
- an event enable register;
- a slot-inserted bitmap, which the bus can only read;
- a slot-removed bitmap, which the bus can only read.

The bus read path is combinational. Bus writes and events take effect at the next clock edge.

Top module: `hotplug_evt_regs`

## Requirements
- R1: Synchronous reset (`rst` high) sets the live and firmware processor bitmaps to a mask with the lowest BOOT_CPUS bits set (0x0003 by default). Reset clears status, enable, both slot bitmaps and `irq_pulse`.
- R2: Each register takes two byte addresses: the even one holds bits 7:0 and the odd one holds bits 15:8. The default offsets are 0x0–0x1 live processor map, 0x2–0x3 firmware copy, 0x4–0x5 status, 0x6–0x7 enable, 0x8–0x9 slot-inserted map and 0xA–0xB slot-removed map.
- R3: Bus writes to the live processor map (offsets 0x0–0x1) are ignored.
- R4: A byte write to status clears exactly the bits where the written byte holds 1. Every other status bit, including all of the other byte, is kept.
- R5: A byte write to the enable register or to the firmware copy replaces only the addressed byte.
- R6: A processor insert sets that processor's bit in the live map and a remove clears it. Either one sets status bit 2 and leaves the firmware copy unchanged.
- R7: A slot event clears both slot maps and then sets the slot's bit: in the inserted map for an insert, in the removed map for a remove. It also sets status bit 1.
- R8: `irq_pulse` goes high for one cycle in the cycle after an event, but only for a processor event while enable bit 2 is 1 or a slot event while enable bit 1 is 1. A processor event and a slot event in the same cycle give a single pulse.
- R9: Events never change the enable register.
- R10: When an event and a write-1-to-clear of its status bit arrive in the same cycle, the bit ends up set.
- R11: Reads of unmapped offsets (0xC–0xF by default) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the block |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for `bus_addr` (combinational) |
| cpu_evt_valid | input | 1 | Processor hotplug event this cycle |
| cpu_evt_idx | input | 4 | Processor index |
| cpu_evt_insert | input | 1 | 1 = insert, 0 = remove |
| slot_evt_valid | input | 1 | Slot hotplug event this cycle |
| slot_evt_idx | input | 4 | Slot index |
| slot_evt_insert | input | 1 | 1 = insert, 0 = remove |
| irq_pulse | output | 1 | One-cycle event interrupt |

## Verification
Byte writes go to every register class at both byte lanes, and the results separate read-only, replace and write-1-to-clear behaviour. Write-1-to-clear is driven with an all-zero byte, a single-bit byte, and a byte aimed at the other lane, to show that exactly the chosen bits clear. Processor and slot events are raised with their enable bit off, with it on, and together in one cycle; these cases separate interrupt gating, pulse length and the bitmap updates. A same-cycle event and status clear shows which of the two wins.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int REG_W       = 16;
    localparam int BYTE_W      = 8;
    localparam int IDX_W       = 4;
    localparam int STS_SLOT_B  = 1;
    localparam int STS_CPU_B   = 2;

    typedef enum logic [2:0] {
        SEL_CPU_LIVE,
        SEL_CPU_FW,
        SEL_STS,
        SEL_EN,
        SEL_SLOT_UP,
        SEL_SLOT_DN,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic              hi;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } bus_acc_t;

    typedef struct packed {
        logic             valid;
        logic             insert;
        logic [IDX_W-1:0] idx;
    } hp_evt_t;

    function automatic logic [REG_W-1:0] lane_replace(
        input logic [REG_W-1:0] cur, input logic hi, input logic [BYTE_W-1:0] d);
        return hi ? {d, cur[BYTE_W-1:0]} : {cur[REG_W-1:BYTE_W], d};
    endfunction

    function automatic logic [REG_W-1:0] lane_clear(
        input logic [REG_W-1:0] cur, input logic hi, input logic [BYTE_W-1:0] d);
        return hi ? (cur & ~{d, {BYTE_W{1'b0}}}) : (cur & ~{{BYTE_W{1'b0}}, d});
    endfunction

    function automatic logic [BYTE_W-1:0] lane_pick(
        input logic [REG_W-1:0] v, input logic hi);
        return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

    function automatic logic [REG_W-1:0] low_mask(input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hp_addr_decode.sv
module hp_addr_decode
    import hp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CPU_BASE  = 0,
    parameter int EVT_BASE  = 4,
    parameter int SLOT_BASE = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output bus_acc_t          acc
);
    localparam int GRP_W = ADDR_W - 2;
    localparam logic [GRP_W-1:0] CPU_GRP  = GRP_W'(CPU_BASE / 4);
    localparam logic [GRP_W-1:0] EVT_GRP  = GRP_W'(EVT_BASE / 4);
    localparam logic [GRP_W-1:0] SLOT_GRP = GRP_W'(SLOT_BASE / 4);

    logic [GRP_W-1:0] grp;
    logic             upper_pair;

    assign grp        = addr[ADDR_W-1:2];
    assign upper_pair = addr[1];

    always_comb begin
        acc.hi    = addr[0];
        acc.wr    = wr;
        acc.wdata = wdata;
        if (grp == CPU_GRP)
            acc.sel = upper_pair ? SEL_CPU_FW : SEL_CPU_LIVE;
        else if (grp == EVT_GRP)
            acc.sel = upper_pair ? SEL_EN : SEL_STS;
        else if (grp == SLOT_GRP)
            acc.sel = upper_pair ? SEL_SLOT_DN : SEL_SLOT_UP;
        else
            acc.sel = SEL_NONE;
    end
endmodule

// File: rtl/hp_cpu_map.sv
module hp_cpu_map
    import hp_pkg::*;
#(
    parameter int NUM_CPU   = 16,
    parameter int BOOT_CPUS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_acc_t         acc,
    input  hp_evt_t          evt,
    output logic [REG_W-1:0] live,
    output logic [REG_W-1:0] fw
);
    localparam logic [REG_W-1:0] BOOT_MASK = low_mask(BOOT_CPUS);

    logic fw_wr;
    assign fw_wr = acc.wr && (acc.sel == SEL_CPU_FW);

    for (genvar b = 0; b < REG_W; b++) begin : g_live
        if (b < NUM_CPU) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    live[b] <= BOOT_MASK[b];
                else if (evt.valid && evt.idx == IDX_W'(b))
                    live[b] <= evt.insert;
            end
        end else begin : g_tie
            assign live[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fw <= BOOT_MASK;
        else if (fw_wr)
            fw <= lane_replace(fw, acc.hi, acc.wdata);
    end

    // R3: a bus write alone never moves the live map
    assert_live_readonly_R3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.sel == SEL_CPU_LIVE && !evt.valid) |=> $stable(live));

    // R6: the addressed processor bit follows the insert flag
    assert_cpu_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && 32'(evt.idx) < NUM_CPU) |=> (live[$past(evt.idx)] == $past(evt.insert)));

    // R6: events leave the firmware copy alone
    assert_fw_untouched_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !fw_wr) |=> $stable(fw));

    // R5: a byte write keeps the other lane
    assert_fw_lane_R5: assert property (@(posedge clk) disable iff (rst)
        (fw_wr && !acc.hi) |=> (fw[REG_W-1:BYTE_W] == $past(fw[REG_W-1:BYTE_W])));
endmodule

// File: rtl/hp_slot_map.sv
module hp_slot_map
    import hp_pkg::*;
#(
    parameter int NUM_SLOT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  hp_evt_t          evt,
    output logic [REG_W-1:0] up_map,
    output logic [REG_W-1:0] dn_map
);
    for (genvar b = 0; b < REG_W; b++) begin : g_slot
        if (b < NUM_SLOT) begin : g_bit
            logic hit;
            assign hit = (evt.idx == IDX_W'(b));
            always_ff @(posedge clk) begin
                if (rst) begin
                    up_map[b] <= 1'b0;
                    dn_map[b] <= 1'b0;
                end else if (evt.valid) begin
                    up_map[b] <= hit && evt.insert;
                    dn_map[b] <= hit && !evt.insert;
                end
            end
        end else begin : g_tie
            assign up_map[b] = 1'b0;
            assign dn_map[b] = 1'b0;
        end
    end

    // R7: after a slot event at most one bit is set across both maps
    assert_slot_single_R7: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> $onehot0({up_map, dn_map}));
endmodule

// File: rtl/hp_event_regs.sv
module hp_event_regs
    import hp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_acc_t         acc,
    input  logic             cpu_hit,
    input  logic             slot_hit,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic             irq
);
    logic [REG_W-1:0] set_mask;
    logic [REG_W-1:0] sts_kept;
    logic             sts_wr;
    logic             en_wr;

    assign sts_wr = acc.wr && (acc.sel == SEL_STS);
    assign en_wr  = acc.wr && (acc.sel == SEL_EN);

    always_comb begin
        set_mask             = '0;
        set_mask[STS_CPU_B]  = cpu_hit;
        set_mask[STS_SLOT_B] = slot_hit;
        sts_kept = sts_wr ? lane_clear(sts, acc.hi, acc.wdata) : sts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
            irq <= 1'b0;
        end else begin
            sts <= sts_kept | set_mask;
            if (en_wr)
                en <= lane_replace(en, acc.hi, acc.wdata);
            irq <= (cpu_hit && en[STS_CPU_B]) || (slot_hit && en[STS_SLOT_B]);
        end
    end

    // R9: only a bus write moves the enable register
    assert_en_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en));

    // R10: an event's bit is set after any same-cycle clear
    assert_evt_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |=> sts[STS_CPU_B]);

    // R8: a pulse always comes with a recorded event class
    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts[STS_CPU_B] || sts[STS_SLOT_B]));

    // R4: a zero byte written to status clears nothing
    assert_zero_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && acc.wdata == '0) |=> ((sts & $past(sts)) == $past(sts)));
endmodule

// File: rtl/hotplug_evt_regs.sv
module hotplug_evt_regs
    import hp_pkg::*;
#(
    parameter int NUM_CPU   = 16,
    parameter int BOOT_CPUS = 2,
    parameter int NUM_SLOT  = 16,
    parameter int ADDR_W    = 4,
    parameter int CPU_BASE  = 0,
    parameter int EVT_BASE  = 4,
    parameter int SLOT_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cpu_evt_valid,
    input  logic [3:0]        cpu_evt_idx,
    input  logic              cpu_evt_insert,
    input  logic              slot_evt_valid,
    input  logic [3:0]        slot_evt_idx,
    input  logic              slot_evt_insert,
    output logic              irq_pulse
);
    bus_acc_t         acc;
    hp_evt_t          cpu_evt, slot_evt;
    logic [REG_W-1:0] live_map, fw_map, sts_reg, en_reg, up_map, dn_map;

    assign cpu_evt  = '{valid: cpu_evt_valid,  insert: cpu_evt_insert,  idx: cpu_evt_idx};
    assign slot_evt = '{valid: slot_evt_valid, insert: slot_evt_insert, idx: slot_evt_idx};

    hp_addr_decode #(
        .ADDR_W(ADDR_W), .CPU_BASE(CPU_BASE), .EVT_BASE(EVT_BASE), .SLOT_BASE(SLOT_BASE)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata), .acc(acc)
    );

    hp_cpu_map #(.NUM_CPU(NUM_CPU), .BOOT_CPUS(BOOT_CPUS)) u_cpu (
        .clk(clk), .rst(rst), .acc(acc), .evt(cpu_evt), .live(live_map), .fw(fw_map)
    );

    hp_slot_map #(.NUM_SLOT(NUM_SLOT)) u_slot (
        .clk(clk), .rst(rst), .evt(slot_evt), .up_map(up_map), .dn_map(dn_map)
    );

    hp_event_regs u_evt (
        .clk(clk), .rst(rst), .acc(acc),
        .cpu_hit(cpu_evt_valid), .slot_hit(slot_evt_valid),
        .sts(sts_reg), .en(en_reg), .irq(irq_pulse)
    );

    always_comb begin
        unique case (acc.sel)
            SEL_CPU_LIVE: bus_rdata = lane_pick(live_map, acc.hi);
            SEL_CPU_FW:   bus_rdata = lane_pick(fw_map,   acc.hi);
            SEL_STS:      bus_rdata = lane_pick(sts_reg,  acc.hi);
            SEL_EN:       bus_rdata = lane_pick(en_reg,   acc.hi);
            SEL_SLOT_UP:  bus_rdata = lane_pick(up_map,   acc.hi);
            SEL_SLOT_DN:  bus_rdata = lane_pick(dn_map,   acc.hi);
            default:      bus_rdata = '0;
        endcase
    end

    // R11: unmapped offsets read as zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (acc.sel == SEL_NONE) |-> (bus_rdata == '0));

    // R11: writes to unmapped offsets leave the registers intact
    assert_unmapped_wr_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && acc.sel == SEL_NONE && !cpu_evt_valid && !slot_evt_valid)
        |=> ($stable(live_map) && $stable(fw_map) && $stable(sts_reg) && $stable(en_reg)));
endmodule

// File: tb/tb_hotplug_evt_regs.sv
module tb_hotplug_evt_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_evt_valid = 1'b0, cpu_evt_insert = 1'b0;
    logic [3:0] cpu_evt_idx = '0;
    logic       slot_evt_valid = 1'b0, slot_evt_insert = 1'b0;
    logic [3:0] slot_evt_idx = '0;
    logic       irq_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hotplug_evt_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_evt_valid(cpu_evt_valid), .cpu_evt_idx(cpu_evt_idx), .cpu_evt_insert(cpu_evt_insert),
        .slot_evt_valid(slot_evt_valid), .slot_evt_idx(slot_evt_idx), .slot_evt_insert(slot_evt_insert),
        .irq_pulse(irq_pulse)
    );

    // {is_write, offset, write byte, expected read byte}
    localparam logic [20:0] VEC [22] = '{
        {1'b0, 4'h0, 8'h00, 8'h03}, {1'b0, 4'h1, 8'h00, 8'h00},
        {1'b0, 4'h2, 8'h00, 8'h03}, {1'b0, 4'h4, 8'h00, 8'h00},
        {1'b0, 4'h6, 8'h00, 8'h00}, {1'b1, 4'h0, 8'hFF, 8'h00},
        {1'b0, 4'h0, 8'h00, 8'h03}, {1'b1, 4'h1, 8'hFF, 8'h00},
        {1'b0, 4'h1, 8'h00, 8'h00}, {1'b1, 4'h6, 8'hA5, 8'h00},
        {1'b0, 4'h6, 8'h00, 8'hA5}, {1'b1, 4'h7, 8'h3C, 8'h00},
        {1'b0, 4'h7, 8'h00, 8'h3C}, {1'b0, 4'h6, 8'h00, 8'hA5},
        {1'b1, 4'h3, 8'h81, 8'h00}, {1'b0, 4'h3, 8'h00, 8'h81},
        {1'b0, 4'h2, 8'h00, 8'h03}, {1'b1, 4'hC, 8'h55, 8'h00},
        {1'b0, 4'hC, 8'h00, 8'h00}, {1'b0, 4'hF, 8'h00, 8'h00},
        {1'b0, 4'h8, 8'h00, 8'h00}, {1'b0, 4'hB, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d,
                        input logic cv, input logic [3:0] ci, input logic cins,
                        input logic sv, input logic [3:0] si, input logic sins);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        cpu_evt_valid = cv; cpu_evt_idx = ci; cpu_evt_insert = cins;
        slot_evt_valid = sv; slot_evt_idx = si; slot_evt_insert = sins;
        @(negedge clk);
        bus_wr = 1'b0; cpu_evt_valid = 1'b0; slot_evt_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq at reset", {7'b0, irq_pulse}, 8'h00);
        rst = 1'b0;

        // table walk: R1 reset values, R2 lanes, R3 read-only live map, R5 byte replace, R11 unmapped
        for (int i = 0; i < 22; i++) begin
            if (VEC[i][20])
                wr(VEC[i][19:16], VEC[i][15:8]);
            else
                rd(VEC[i][19:16], VEC[i][7:0], $sformatf("R1/R2/R3/R5/R11 vector %0d", i));
        end

        // R6 processor insert with enable bit 2 off: no pulse (R8)
        wr(4'h6, 8'h00);
        step(1'b0, 4'h0, 8'h00, 1'b1, 4'd5, 1'b1, 1'b0, 4'h0, 1'b0);
        chk("R8 gated irq", {7'b0, irq_pulse}, 8'h00);
        rd(4'h0, 8'h23, "R6 live insert");
        rd(4'h2, 8'h03, "R6 fw unchanged");
        rd(4'h4, 8'h04, "R6 status bit2");
        rd(4'h6, 8'h00, "R9 enable kept");

        // R8 processor remove with enable bit 2 on
        wr(4'h6, 8'h04);
        step(1'b0, 4'h0, 8'h00, 1'b1, 4'd0, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R8 irq pulse", {7'b0, irq_pulse}, 8'h01);
        @(negedge clk);
        chk("R8 irq one cycle", {7'b0, irq_pulse}, 8'h00);
        rd(4'h0, 8'h22, "R6 live remove");
        rd(4'h6, 8'h04, "R9 enable after event");

        // R4 write-1-to-clear
        wr(4'h4, 8'h00);
        rd(4'h4, 8'h04, "R4 zero byte clears nothing");
        step(1'b0, 4'h0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 4'd3, 1'b1);
        chk("R8 slot gated", {7'b0, irq_pulse}, 8'h00);
        rd(4'h4, 8'h06, "R7 status bit1");
        rd(4'h8, 8'h08, "R7 up map");
        rd(4'hA, 8'h00, "R7 down map");
        wr(4'h4, 8'h02);
        rd(4'h4, 8'h04, "R4 single bit clear");
        wr(4'h5, 8'hFF);
        rd(4'h4, 8'h04, "R4 other lane kept");

        // R7 remove clears the earlier insert
        step(1'b0, 4'h0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 4'd9, 1'b0);
        rd(4'h8, 8'h00, "R7 up cleared");
        rd(4'h9, 8'h00, "R7 up hi");
        rd(4'hA, 8'h00, "R7 down lo");
        rd(4'hB, 8'h02, "R7 down hi");

        // R8 simultaneous events give one pulse
        wr(4'h6, 8'h06);
        step(1'b0, 4'h0, 8'h00, 1'b1, 4'd12, 1'b1, 1'b1, 4'd1, 1'b1);
        chk("R8 joint pulse", {7'b0, irq_pulse}, 8'h01);
        @(negedge clk);
        chk("R8 joint pulse ends", {7'b0, irq_pulse}, 8'h00);
        rd(4'h8, 8'h02, "R7 up after joint");
        rd(4'hB, 8'h00, "R7 down cleared");
        rd(4'h1, 8'h10, "R6 live hi");
        rd(4'h6, 8'h06, "R9 enable lo");
        rd(4'h7, 8'h3C, "R9 enable hi");

        // R10 event set beats a same-cycle clear
        wr(4'h4, 8'hFF);
        rd(4'h4, 8'h00, "R4 full clear");
        step(1'b1, 4'h4, 8'hFF, 1'b1, 4'd7, 1'b1, 1'b0, 4'h0, 1'b0);
        rd(4'h4, 8'h04, "R10 set wins");
        rd(4'h0, 8'hA2, "R6 live bit7");

        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(4'h0, 8'h03, "R1 live lo");
        rd(4'h1, 8'h00, "R1 live hi");
        rd(4'h3, 8'h00, "R1 fw hi");
        rd(4'h4, 8'h00, "R1 status");
        rd(4'h7, 8'h00, "R1 enable");
        rd(4'h8, 8'h00, "R1 up map");
        chk("R1 irq", {7'b0, irq_pulse}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule